// File: doc/BRIEF.md
# Multilevel Pipeline Register File

This block holds four data registers that all update on the rising clock edge. A 2-bit operation code picks how they are organised on each edge. They can work as two separate 2-level pipelines, called A and B, or as one 4-level shift chain. A third choice holds every register. A single data input feeds the chain, and a 2-bit select code routes any one register to the data output.

The output has three states. It drives the selected register while the active-low output enable is low, and it is released to high impedance while the enable is high.

A build-time parameter picks one of two load variants for the 2-level loads:
- **Push variant:** a load moves the old first-level word of that pipeline down into its second level.
- **Overwrite variant:** a load replaces only the first-level word. In this variant the 4-level shift is the only path into a second level.

Top module: `multilevel_pipe_regs`

Operation codes, decoded in priority-free `unique case` form:
- **OP_SHIFT (0):** the 4-level shift.
- **OP_LOAD_B (1):** load pipeline B.
- **OP_LOAD_A (2):** load pipeline A.
- **OP_HOLD (3):** hold all registers.

Each register's next value comes from one of three sources:
- **SRC_KEEP:** the register keeps its word.
- **SRC_DIN:** the register takes the data input.
- **SRC_UP:** the register takes the word of its upstream neighbour.

## Requirements
- R1: `rst` is synchronous and active high. At a rising edge with `rst` high, all four registers (A1, A2, B1, B2) become zero. Raising `rst` between edges changes nothing until the next edge.
- R2: The output path is combinational. While `oe_n` is low, `osel` value 0 shows B2, 1 shows B1, 2 shows A2 and 3 shows A1 on `dout`.
- R3: While `oe_n` is high, `dout` is high impedance on every bit, so another driver on the same net sets its level. While `oe_n` is low, the block drives `dout`.
- R4: Operation code 3 holds. No register changes, whatever the value of `din`.
- R5: Operation code 2 writes `din` into A1 and leaves B1 and B2 unchanged.
- R6: Operation code 1 writes `din` into B1 and leaves A1 and A2 unchanged.
- R7: In the push variant (`PUSH_LOAD` = 1), code 2 also moves the old A1 into A2, and code 1 also moves the old B1 into B2.
- R8: In the overwrite variant (`PUSH_LOAD` = 0), codes 2 and 1 leave A2 and B2 unchanged.
- R9: Operation code 0 shifts the four registers as one chain. A1 takes `din`, A2 takes the old A1, B1 takes the old A2 and B2 takes the old B1. The old B2 is lost. The shift behaves the same in both variants.
- R10: A register takes its new value only at a rising edge. A change of `din` or `op` between edges leaves `dout` unchanged until the next edge. The value loaded is the one present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| din | input | WIDTH | Data word entering the first level |
| op | input | 2 | Operation code: 0 shift, 1 load B, 2 load A, 3 hold |
| osel | input | 2 | Output select: 0 B2, 1 B1, 2 A2, 3 A1 |
| oe_n | input | 1 | Active-low output enable |
| dout | output | WIDTH | Selected register word, or high impedance |

## Verification
Every register can be read directly through `osel` with no delay. A register loaded from the wrong source therefore shows a wrong word on `dout` in the same cycle as the edge that loaded it. A wrong choice between push and overwrite shows at the second-level select codes right after the first load into a pipeline that already holds data. An error in the order of the shift chain appears after one shift at the position of the neighbour concerned, and it spreads one level further with each later shift.

// File: rtl/pipe_regs_pkg.sv
`timescale 1ns/1ps
package pipe_regs_pkg;

    localparam int NUM_STAGES = 4;
    localparam int SEL_W      = $clog2(NUM_STAGES);

    // Register positions; the output-select code equals the position.
    localparam int IDX_B2 = 0;
    localparam int IDX_B1 = 1;
    localparam int IDX_A2 = 2;
    localparam int IDX_A1 = 3;

    typedef enum logic [1:0] {
        OP_SHIFT  = 2'd0,
        OP_LOAD_B = 2'd1,
        OP_LOAD_A = 2'd2,
        OP_HOLD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SRC_KEEP = 2'd0,
        SRC_DIN  = 2'd1,
        SRC_UP   = 2'd2
    } src_e;

endpackage

// File: rtl/pipe_op_decoder.sv
`timescale 1ns/1ps
module pipe_op_decoder
    import pipe_regs_pkg::*;
#(
    parameter bit PUSH_LOAD = 1'b1
) (
    input  op_e  op,
    output src_e src [NUM_STAGES]
);

    always_comb begin
        for (int i = 0; i < NUM_STAGES; i++) begin
            src[i] = SRC_KEEP;
        end
        unique case (op)
            OP_SHIFT: begin
                // Whole chain moves one level towards B2.
                src[IDX_A1] = SRC_DIN;
                src[IDX_A2] = SRC_UP;
                src[IDX_B1] = SRC_UP;
                src[IDX_B2] = SRC_UP;
            end
            OP_LOAD_A: begin
                src[IDX_A1] = SRC_DIN;
                if (PUSH_LOAD) src[IDX_A2] = SRC_UP;
            end
            OP_LOAD_B: begin
                // B1 is fed from din here, so B2 takes upstream = old B1.
                src[IDX_B1] = SRC_DIN;
                if (PUSH_LOAD) src[IDX_B2] = SRC_UP;
            end
            OP_HOLD: begin
                // all sources stay SRC_KEEP
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pipe_stage_reg.sv
`timescale 1ns/1ps
module pipe_stage_reg
    import pipe_regs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  src_e             src,
    input  logic [WIDTH-1:0] d_din,
    input  logic [WIDTH-1:0] d_up,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (src)
            SRC_DIN: q_next = d_din;
            SRC_UP:  q_next = d_up;
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

endmodule

// File: rtl/pipe_out_select.sv
`timescale 1ns/1ps
module pipe_out_select
    import pipe_regs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] q [NUM_STAGES],
    input  logic [SEL_W-1:0] osel,
    input  logic             oe_n,
    output logic [WIDTH-1:0] sel_q,
    output logic [WIDTH-1:0] dout
);

    always_comb begin
        sel_q = q[osel];
    end

    assign dout = oe_n ? {WIDTH{1'bz}} : sel_q;

endmodule

// File: rtl/multilevel_pipe_regs.sv
`timescale 1ns/1ps
module multilevel_pipe_regs
    import pipe_regs_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter bit PUSH_LOAD = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic [1:0]       op,
    input  logic [1:0]       osel,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout
);

    src_e             src   [NUM_STAGES];
    logic [WIDTH-1:0] q     [NUM_STAGES];
    logic [WIDTH-1:0] sel_q;

    pipe_op_decoder #(.PUSH_LOAD(PUSH_LOAD)) u_dec (
        .op  (op_e'(op)),
        .src (src)
    );

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] up_word;
        if (i == NUM_STAGES - 1) begin : g_head
            assign up_word = din;
        end else begin : g_body
            assign up_word = q[i+1];
        end
        pipe_stage_reg #(.WIDTH(WIDTH)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .src   (src[i]),
            .d_din (din),
            .d_up  (up_word),
            .q     (q[i])
        );
    end

    pipe_out_select #(.WIDTH(WIDTH)) u_out (
        .q     (q),
        .osel  (osel),
        .oe_n  (oe_n),
        .sel_q (sel_q),
        .dout  (dout)
    );

endmodule

// File: rtl/pipe_regs_checker.sv
`timescale 1ns/1ps
module pipe_regs_checker #(
    parameter int WIDTH     = 8,
    parameter bit PUSH_LOAD = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] din,
    input logic [1:0]       op,
    input logic [1:0]       osel,
    input logic [WIDTH-1:0] sel_q,
    input logic [WIDTH-1:0] a1,
    input logic [WIDTH-1:0] a2,
    input logic [WIDTH-1:0] b1,
    input logic [WIDTH-1:0] b2
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (a1 == '0 && a2 == '0 && b1 == '0 && b2 == '0));

    a_r2_sel_b2: assert property (@(posedge clk) disable iff (rst)
        (osel == 2'd0) |-> (sel_q == b2));

    a_r2_sel_a1: assert property (@(posedge clk) disable iff (rst)
        (osel == 2'd3) |-> (sel_q == a1));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd3) |=> ($stable(a1) && $stable(a2) && $stable(b1) && $stable(b2)));

    a_r5_load_a: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd2) |=> (a1 == $past(din) && $stable(b1) && $stable(b2)));

    a_r6_load_b: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd1) |=> (b1 == $past(din) && $stable(a1) && $stable(a2)));

    a_r9_shift: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd0) |=> (a1 == $past(din) && a2 == $past(a1) &&
                          b1 == $past(a2) && b2 == $past(b1)));

    if (PUSH_LOAD) begin : g_push
        a_r7_push_a: assert property (@(posedge clk) disable iff (rst)
            (op == 2'd2) |=> (a2 == $past(a1)));
        a_r7_push_b: assert property (@(posedge clk) disable iff (rst)
            (op == 2'd1) |=> (b2 == $past(b1)));
    end else begin : g_ovr
        a_r8_keep_a2: assert property (@(posedge clk) disable iff (rst)
            (op == 2'd2) |=> $stable(a2));
        a_r8_keep_b2: assert property (@(posedge clk) disable iff (rst)
            (op == 2'd1) |=> $stable(b2));
    end

endmodule

bind multilevel_pipe_regs pipe_regs_checker #(
    .WIDTH     (WIDTH),
    .PUSH_LOAD (PUSH_LOAD)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .op    (op),
    .osel  (osel),
    .sel_q (sel_q),
    .a1    (q[3]),
    .a2    (q[2]),
    .b1    (q[1]),
    .b2    (q[0])
);

// File: tb/test_multilevel_pipe_regs.sv
`timescale 1ns/1ps
module test_multilevel_pipe_regs;

    localparam int W = 8;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  din;
        logic [31:0] exp_push;  // {A1,A2,B1,B2}
        logic [31:0] exp_ovr;   // {A1,A2,B1,B2}
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{2'd2, 8'h11, 32'h11000000, 32'h11000000},
        '{2'd2, 8'h22, 32'h22110000, 32'h22000000},
        '{2'd1, 8'h33, 32'h22113300, 32'h22003300},
        '{2'd1, 8'h44, 32'h22114433, 32'h22004400},
        '{2'd3, 8'h55, 32'h22114433, 32'h22004400},
        '{2'd0, 8'h66, 32'h66221144, 32'h66220044},
        '{2'd0, 8'h77, 32'h77662211, 32'h77662200},
        '{2'd2, 8'h88, 32'h88772211, 32'h88662200},
        '{2'd1, 8'h99, 32'h88779922, 32'h88669900},
        '{2'd3, 8'hAA, 32'h88779922, 32'h88669900}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [1:0]   op = 2'd3;
    logic [1:0]   osel = 2'd0;
    logic         oe_n = 1'b0;
    logic         tb_en = 1'b0;
    logic [W-1:0] tb_pat = '0;
    wire  [W-1:0] bus_p;
    wire  [W-1:0] bus_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    assign bus_p = tb_en ? tb_pat : {W{1'bz}};

    multilevel_pipe_regs #(.WIDTH(W), .PUSH_LOAD(1'b1)) i_multilevel_pipe_regs (
        .clk (clk), .rst (rst), .din (din), .op (op),
        .osel (osel), .oe_n (oe_n), .dout (bus_p)
    );

    multilevel_pipe_regs #(.WIDTH(W), .PUSH_LOAD(1'b0)) i_multilevel_pipe_regs_ovr (
        .clk (clk), .rst (rst), .din (din), .op (op),
        .osel (osel), .oe_n (oe_n), .dout (bus_o)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic string op_tag(input logic [1:0] o);
        case (o)
            2'd0:    return "R9 shift";
            2'd1:    return "R6 load B";
            2'd2:    return "R5 load A";
            default: return "R4 hold";
        endcase
    endfunction

    // Reads all four registers of both instances through osel (R2).
    task automatic read_all(input string tag, input logic [31:0] ep, input logic [31:0] eo);
        for (int j = 0; j < 4; j++) begin
            osel = 2'(j);
            #1;
            check({tag, " R7 push / R2 sel"}, bus_p, ep[j*8 +: 8]);
            check({tag, " R8 overwrite / R2 sel"}, bus_o, eo[j*8 +: 8]);
        end
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state is all zero
        read_all("R1 reset state", 32'h0, 32'h0);

        // Table walk
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            op  = VECS[k].op;
            din = VECS[k].din;
            @(posedge clk);
            #2;
            op = 2'd3;
            read_all(op_tag(VECS[k].op), VECS[k].exp_push, VECS[k].exp_ovr);
        end

        // R10: din changes between edges do not reach A1 until the edge
        @(negedge clk);
        osel = 2'd3;
        op   = 2'd2;
        din  = 8'hC3;
        #2;
        check("R10 no early load", bus_p, 8'h88);
        check("R10 no early load", bus_o, 8'h88);
        din = 8'h3C;
        #2;
        check("R10 no early load", bus_p, 8'h88);
        @(posedge clk);
        #2;
        op = 2'd3;
        check("R10 edge value loaded", bus_p, 8'h3C);
        check("R10 edge value loaded", bus_o, 8'h3C);
        osel = 2'd2;
        #1;
        check("R7 push A2 after load", bus_p, 8'h88);
        check("R8 overwrite A2 kept", bus_o, 8'h66);

        // R3: released output lets another driver set the net
        @(negedge clk);
        osel   = 2'd3;
        oe_n   = 1'b1;
        tb_en  = 1'b1;
        tb_pat = 8'h5A;
        #1;
        check("R3 released output", bus_p, 8'h5A);
        tb_pat = 8'hA5;
        #1;
        check("R3 released output", bus_p, 8'hA5);
        tb_en = 1'b0;
        oe_n  = 1'b0;
        #1;
        check("R3 driven output", bus_p, 8'h3C);

        // R1: synchronous reset waits for the edge
        @(negedge clk);
        rst = 1'b1;
        #2;
        check("R1 sync reset before edge", bus_p, 8'h3C);
        @(posedge clk);
        #2;
        rst = 1'b0;
        read_all("R1 reset clears", 32'h0, 32'h0);

        report();
    end

endmodule